// File: doc/BRIEF.md
# Multichannel Time-Slot Scheduler

This block folds a set of parallel sample channels onto a smaller number of fast output lanes. Each lane carries a stream of data, a valid flag and an 8-bit channel number, and data on a lane counts only while its valid flag is high. The ratio of the clock rate to the per-channel sample rate sets how many time slots each lane offers per sample period. That slot count sets how many lanes are needed, and the lane count in turn sets how many channels each lane carries. All three values are derived at elaboration from parameters.

Channels are spread evenly over the lanes rather than packed into the first lane. A free-running slot counter steps through each frame. Once per frame, at slot 0, a complete set of per-channel input samples is captured. Each lane then emits one channel per slot from that set. Slots with no channel assigned to them are sent with valid low and zero payload.

Top module: `tdm_slot_scheduler`

## Requirements
- R1: The slot count per lane is floor(CLK_RATE / SAMPLE_RATE). The slot counter runs 0 to slots-1 and wraps, so every lane's pattern repeats with that period.
- R2: The lane count is ceil(NCH / slots) and the channels per lane are ceil(NCH / lanes). If channels per lane would exceed the slot count, or NCH exceeds 256, elaboration stops.
- R3: Lane w, slot s carries channel number w*channelsPerLane + s in its 8-bit channel field, which sits at bits [8w+7:8w] of `lane_chan`.
- R4: A slot is valid only when s < channelsPerLane and the computed channel number is below NCH. For example, with 3 slots and 2 channels the valid flag is high for two cycles and low for one in every frame.
- R5: On an invalid slot the lane drives zero on both its data field and its channel field.
- R6: `in_frame` (channel c at bits [c*DW+DW-1:c*DW]) is sampled only at the clock edge where the slot counter is 0. Changes at any other edge have no effect on the lanes until the next capture.
- R7: On a valid slot, the lane data (lane w at bits [w*DW+DW-1:w*DW]) equals the sample of the carried channel from the most recent capture.
- R8: A synchronous active-high reset returns the slot counter to 0 and holds all valid flags low. After the first edge with reset low, the lanes present slot 0 of a freshly captured frame. Lane outputs are registered, so the edge that processes slot s also drives slot s onto the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_frame | input | NCH*DW | One sample per channel, channel c at bits [c*DW+DW-1:c*DW] |
| lane_data | output | LANES*DW | Per-lane payload, lane w at bits [w*DW+DW-1:w*DW] |
| lane_valid | output | LANES | Per-lane valid flag |
| lane_chan | output | LANES*8 | Per-lane channel number, lane w at bits [8w+7:8w] |

## Verification
The bench runs three geometries:
- Four channels on three slots, which needs two lanes. A design that filled the first lane before the second would put channel 2 on lane 0 and fail the channel-number checks.
- Two channels on three slots, which checks the two-on, one-off valid pattern.
- Five channels on floor(9/2)=4 slots, which leaves the last computed channel number out of range. A design that tested only the slot index would raise valid on that nonexistent channel.

Between captures the inputs are scrambled. A design that read `in_frame` live, rather than from the captured frame, would show the scrambled values. Reset is also asserted partway through a frame, which catches a counter that keeps its phase through reset.

// File: rtl/tdm_sched_pkg.sv
`timescale 1ns/1ps
package tdm_sched_pkg;
    localparam int CHAN_ID_W = 8;

    function automatic int slots_per_lane(input int clk_rate, input int sample_rate);
        return clk_rate / sample_rate;
    endfunction

    function automatic int lane_count(input int nch, input int slots);
        return (nch + slots - 1) / slots;
    endfunction

    function automatic int chans_per_lane(input int nch, input int lanes);
        return (nch + lanes - 1) / lanes;
    endfunction

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
`timescale 1ns/1ps
module tdm_slot_counter
    import tdm_sched_pkg::*;
#(
    parameter  int SLOTS = 3,
    localparam int SW    = idx_width(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_o,
    output logic          frame_start_o
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST) st_d.slot = '0;
        else                   st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slot_o        = st_q.slot;
    assign frame_start_o = (st_q.slot == '0);

    // R1: frame length equals the slot count
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.slot == LAST) |=> (st_q.slot == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.slot != LAST) |=> (st_q.slot == SW'($past(st_q.slot) + 1'b1)));
endmodule

// File: rtl/tdm_frame_latch.sv
`timescale 1ns/1ps
module tdm_frame_latch #(
    parameter  int NCH = 4,
    parameter  int DW  = 16,
    localparam int FW  = NCH * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture_i,
    input  logic [FW-1:0] frame_i,
    output logic [FW-1:0] held_o
);
    typedef struct packed {
        logic [FW-1:0] frame;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) st_d.frame = frame_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held_o = st_q.frame;

    // R6: held samples change only at a capture edge
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(held_o));
endmodule

// File: rtl/tdm_lane_map.sv
`timescale 1ns/1ps
module tdm_lane_map
    import tdm_sched_pkg::*;
#(
    parameter  int DW       = 16,
    parameter  int NCH      = 4,
    parameter  int SLOTS    = 3,
    parameter  int CPW      = 2,
    parameter  int LANE_IDX = 0,
    localparam int SW       = idx_width(SLOTS),
    localparam int FW       = NCH * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SW-1:0]        slot_i,
    input  logic                 start_i,
    input  logic [FW-1:0]        live_i,
    input  logic [FW-1:0]        held_i,
    output logic [DW-1:0]        data_o,
    output logic                 valid_o,
    output logic [CHAN_ID_W-1:0] chan_o
);
    localparam int unsigned BASE = LANE_IDX * CPW;

    typedef struct packed {
        logic [DW-1:0]        data;
        logic                 valid;
        logic [CHAN_ID_W-1:0] chan;
    } lane_t;

    lane_t         ln_d, ln_q;
    int unsigned   ch_idx;
    logic          hit;
    logic [FW-1:0] src;

    always_comb begin
        ch_idx = BASE + 32'(slot_i);
        hit    = (32'(slot_i) < CPW) && (ch_idx < NCH);
        src    = start_i ? live_i : held_i;
        ln_d   = '0;
        ln_d.valid = hit;
        if (hit) ln_d.chan = CHAN_ID_W'(ch_idx);
        for (int c = 0; c < NCH; c++) begin
            if (hit && (ch_idx == 32'(c))) ln_d.data = src[c*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '0;
        else     ln_q <= ln_d;
    end

    assign data_o  = ln_q.data;
    assign valid_o = ln_q.valid;
    assign chan_o  = ln_q.chan;

    // R5: idle slots carry zero payload and zero channel
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !ln_q.valid |-> (ln_q.data == '0 && ln_q.chan == '0));
    // R4: a valid slot lies inside the per-lane channel count
    p_valid_slot_r4: assert property (@(posedge clk) disable iff (rst)
        ln_q.valid |-> (32'($past(slot_i)) < CPW));
    // R3: channel number follows lane and slot
    p_chan_map_r3: assert property (@(posedge clk) disable iff (rst)
        ln_q.valid |-> (32'(ln_q.chan) == BASE + 32'($past(slot_i))));
    // R8: nothing valid right after reset
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !ln_q.valid);
endmodule

// File: rtl/tdm_slot_scheduler.sv
`timescale 1ns/1ps
module tdm_slot_scheduler
    import tdm_sched_pkg::*;
#(
    parameter  int CLK_RATE    = 3,
    parameter  int SAMPLE_RATE = 1,
    parameter  int NCH         = 4,
    parameter  int DW          = 16,
    localparam int SLOTS       = slots_per_lane(CLK_RATE, SAMPLE_RATE),
    localparam int LANES       = lane_count(NCH, SLOTS),
    localparam int CPW         = chans_per_lane(NCH, LANES),
    localparam int SW          = idx_width(SLOTS),
    localparam int FW          = NCH * DW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [FW-1:0]              in_frame,
    output logic [LANES*DW-1:0]        lane_data,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES*CHAN_ID_W-1:0] lane_chan
);
    // R2: geometry must fit the slots and the channel field
    if (SLOTS < 1 || CPW > SLOTS || NCH > 256 || NCH < 1) begin : g_bad_geometry
        $error("tdm_slot_scheduler: unsupported slot/channel geometry");
    end

    logic [SW-1:0] slot;
    logic          frame_start;
    logic [FW-1:0] held;

    tdm_slot_counter #(.SLOTS(SLOTS)) u_counter (
        .clk           (clk),
        .rst           (rst),
        .slot_o        (slot),
        .frame_start_o (frame_start)
    );

    tdm_frame_latch #(.NCH(NCH), .DW(DW)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .capture_i (frame_start),
        .frame_i   (in_frame),
        .held_o    (held)
    );

    for (genvar w = 0; w < LANES; w++) begin : g_lane
        tdm_lane_map #(
            .DW(DW), .NCH(NCH), .SLOTS(SLOTS), .CPW(CPW), .LANE_IDX(w)
        ) u_map (
            .clk     (clk),
            .rst     (rst),
            .slot_i  (slot),
            .start_i (frame_start),
            .live_i  (in_frame),
            .held_i  (held),
            .data_o  (lane_data[w*DW +: DW]),
            .valid_o (lane_valid[w]),
            .chan_o  (lane_chan[w*CHAN_ID_W +: CHAN_ID_W])
        );
    end
endmodule

// File: tb/tdm_slot_scheduler_tb_top.sv
`timescale 1ns/1ps
module tdm_sched_harness #(
    parameter int CLK_RATE    = 3,
    parameter int SAMPLE_RATE = 1,
    parameter int NCH         = 4,
    parameter int DW          = 16,
    parameter int CFG         = 0
) (
    input  logic clk,
    output logic done,
    output int   n_checks,
    output int   n_fails
);
    // Geometry worked out from R1 and R2
    localparam int S  = CLK_RATE / SAMPLE_RATE;
    localparam int W  = (NCH + S - 1) / S;
    localparam int CP = (NCH + W - 1) / W;
    localparam int FW = NCH * DW;

    typedef struct {
        logic [W*DW-1:0] data;
        logic [W-1:0]    valid;
        logic [W*8-1:0]  chan;
    } exp_t;

    exp_t sb_q[$];

    logic            rst;
    logic [FW-1:0]   in_frame;
    logic [W*DW-1:0] lane_data;
    logic [W-1:0]    lane_valid;
    logic [W*8-1:0]  lane_chan;

    tdm_slot_scheduler #(
        .CLK_RATE(CLK_RATE), .SAMPLE_RATE(SAMPLE_RATE), .NCH(NCH), .DW(DW)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_frame   (in_frame),
        .lane_data  (lane_data),
        .lane_valid (lane_valid),
        .lane_chan  (lane_chan)
    );

    function automatic logic [FW-1:0] frame_pat(input int f);
        logic [FW-1:0] v;
        v = '0;
        for (int c = 0; c < NCH; c++) begin
            case (f % 4)
                0:       v[c*DW +: DW] = DW'(c + 1 + f * 16);
                1:       v[c*DW +: DW] = '1;
                2:       v[c*DW +: DW] = DW'(1) << (c % DW);
                default: v[c*DW +: DW] = DW'((CFG + 5) * (c + 3) * (f + 7) * 97);
            endcase
        end
        return v;
    endfunction

    // R3, R4, R5, R7: expected lane contents for one slot
    function automatic exp_t make_exp(input logic [FW-1:0] fr, input int s);
        exp_t e;
        e.data = '0; e.valid = '0; e.chan = '0;
        for (int w = 0; w < W; w++) begin
            int ch;
            ch = w * CP + s;
            if (s < CP && ch < NCH) begin
                e.valid[w]       = 1'b1;
                e.chan[w*8 +: 8] = 8'(ch);
                e.data[w*DW +: DW] = fr[ch*DW +: DW];
            end
        end
        return e;
    endfunction

    task automatic check_slot(input exp_t e);
        for (int w = 0; w < W; w++) begin
            logic          av, ev;
            logic [7:0]    ac, ec;
            logic [DW-1:0] ad, ed;
            string         tag;
            av = lane_valid[w];     ev = e.valid[w];
            ac = lane_chan[w*8 +: 8]; ec = e.chan[w*8 +: 8];
            ad = lane_data[w*DW +: DW]; ed = e.data[w*DW +: DW];
            n_checks++;
            if (av !== ev || ac !== ec || ad !== ed) begin
                n_fails++;
                if (av !== ev)      tag = "R4";
                else if (ac !== ec) tag = "R3";
                else if (ev)        tag = "R7/R6";
                else                tag = "R5";
                $display("FAIL %s cfg %0d lane %0d: got v=%0b ch=%0d d=%h, expected v=%0b ch=%0d d=%h",
                         tag, CFG, w, av, ac, ad, ev, ec, ed);
            end
        end
    endtask

    // R8: reset forces every valid flag low
    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (cycles) begin
            @(posedge clk);
            #5;
            n_checks++;
            if (lane_valid !== '0) begin
                n_fails++;
                $display("FAIL R8 cfg %0d: got valid=%b, expected valid=%b",
                         CFG, lane_valid, {W{1'b0}});
            end
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver pushes the expected frame; R6: inputs scrambled between captures.
    // R1, R2: monitor pops one entry per cycle, so frame period and lane layout are checked.
    task automatic run_frames(input int nframes, input int base);
        fork
            begin
                for (int f = 0; f < nframes; f++) begin
                    logic [FW-1:0] cur;
                    cur = frame_pat(base + f);
                    in_frame = cur;
                    for (int s = 0; s < S; s++) sb_q.push_back(make_exp(cur, s));
                    for (int k = 1; k < S; k++) begin
                        @(negedge clk);
                        in_frame = ~cur ^ FW'(k * 12345);
                    end
                    @(negedge clk);
                end
            end
            begin
                repeat (nframes * S) begin
                    @(posedge clk);
                    #5;
                    if (sb_q.size() == 0) begin
                        n_checks++;
                        n_fails++;
                        $display("FAIL R1 cfg %0d: got output with empty scoreboard, expected a queued slot", CFG);
                    end else begin
                        check_slot(sb_q.pop_front());
                    end
                end
            end
        join
    endtask

    initial begin
        done     = 1'b0;
        n_checks = 0;
        n_fails  = 0;
        rst      = 1'b1;
        in_frame = '0;
        do_reset(3);
        run_frames(6, 0);
        in_frame = '1;
        do_reset(2);          // mid-frame reset, R8
        run_frames(4, 10);
        do_reset(1);
        run_frames(3, 21);
        done = 1'b1;
    end
endmodule

module tdm_slot_scheduler_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic done_a, done_b, done_c;
    int   chk_a, chk_b, chk_c, bad_a, bad_b, bad_c;

    // 4 channels on 3 slots: 2 lanes of 2
    tdm_sched_harness #(.CLK_RATE(3), .SAMPLE_RATE(1), .NCH(4), .DW(16), .CFG(0)) h_a (
        .clk(clk), .done(done_a), .n_checks(chk_a), .n_fails(bad_a));
    // 2 channels on 3 slots: valid two of three
    tdm_sched_harness #(.CLK_RATE(3), .SAMPLE_RATE(1), .NCH(2), .DW(12), .CFG(1)) h_b (
        .clk(clk), .done(done_b), .n_checks(chk_b), .n_fails(bad_b));
    // 5 channels on floor(9/2)=4 slots: 2 lanes of 3, one out-of-range slot
    tdm_sched_harness #(.CLK_RATE(9), .SAMPLE_RATE(2), .NCH(5), .DW(8), .CFG(2)) h_c (
        .clk(clk), .done(done_c), .n_checks(chk_c), .n_fails(bad_c));

    initial begin
        bit timed_out;
        int total, fails;
        timed_out = 1'b0;
        fork
            wait (done_a && done_b && done_c);
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        total = chk_a + chk_b + chk_c;
        fails = bad_a + bad_b + bad_c;
        if (timed_out) begin
            total++;
            fails++;
            $display("FAIL watchdog: got no completion, expected all harnesses done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end
endmodule